// File: doc/BRIEF.md
# Bus Ownership Controller

This block decides, clock by clock, whether the processor side of a bus interface drives the shared bus. It tracks a single bus cycle requested by the core. It launches that cycle when the bus is owned. It gives the bus away through three different release paths:

- **Address-only hold.** Only the address group stops being driven; the rest of the bus keeps running.
- **Graceful hold.** The bus is handed over only after the outstanding cycle has completed. Handover is marked by a hold acknowledge.
- **Backoff.** The bus is dropped at once. The running cycle is abandoned and later reissued from the start.

The core offers a cycle with a request strobe and an address, and may do so only while the block reports it is ready. The block shows a cycle launch as a one-clock start pulse that carries the address. The external system ends the cycle with a ready input. The bus-request output shows that a cycle is waiting or running, and it stays valid while the bus is released. The output enables are active-high. All inputs are sampled on the rising clock edge, and reset is synchronous and active-high.

Top module: `bus_hold_ctl`

## Requirements
- R1: After reset with no hold request, busOe and addrOe are 1, holdAck, busReq and cycStart are 0, and coreReady is 1.
- R2: A request taken while coreReady is 1 sets busReq and clears coreReady from the next clock. cycStart is a one-clock pulse in the second clock after acceptance, with cycAddrOut equal to the accepted address. cycReady while the cycle runs clears busReq and sets coreReady in the next clock.
- R3: addrHoldReq sampled high makes addrOe 0 from the next clock while busOe stays 1. A running cycle can still complete. No cycle starts until addrOe is 1 again.
- R4: holdAck is never 1 while a cycle is outstanding. It rises in the clock after the edge at which holdReq is sampled with no cycle outstanding, including the edge at which cycReady ends the cycle. While holdAck is 1, busOe and addrOe are 0.
- R5: While lockActive is 1, holdReq has no effect, and holdAck follows in the clock after lockActive drops.
- R6: holdReq high during reset yields holdAck 1 with busOe 0 while reset is still asserted.
- R7: When holdReq is removed, holdAck is 0 and busOe is 1 from the next clock. A waiting cycle's cycStart comes exactly one clock after holdAck falls.
- R8: backoffReq sampled high makes busOe and addrOe 0 in the next clock. A running cycle is aborted even if cycReady is high on the same edge, so busReq stays 1 and coreReady stays 0.
- R9: After backoffReq is removed, busOe returns to 1 in the next clock. The aborted cycle is reissued with the same address one clock later, and it then completes normally.
- R10: busReq reflects a waiting cycle at all times, including while holdAck is 1.
- R11: With backoffReq and holdReq both high, backoffReq wins and holdAck stays 0. holdAck rises in the clock after backoff clears only if holdReq is still high; otherwise the bus returns to owned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addrHoldReq | input | 1 | Request to stop driving the address group |
| backoffReq | input | 1 | Immediate abort-and-release request |
| holdReq | input | 1 | Graceful bus hold request |
| lockActive | input | 1 | Locked sequence in progress; blocks hold |
| cycReq | input | 1 | Core offers a new bus cycle |
| cycAddr | input | ADDR_W | Address of the offered cycle |
| cycReady | input | 1 | External completion of the running cycle |
| holdAck | output | 1 | Bus released to another master |
| addrOe | output | 1 | Drive enable for address and address parity |
| busOe | output | 1 | Drive enable for control and data group |
| busReq | output | 1 | A cycle is waiting or running |
| cycStart | output | 1 | One-clock pulse: cycle launched on the bus |
| cycAddrOut | output | ADDR_W | Address of the launched cycle |
| coreReady | output | 1 | Core may offer the next cycle |

## Verification
The bench drives cycReady on the same edge as backoffReq. A design that lets completion win would free the slot and lose the reissue. It ends a cycle on the very edge where holdReq is waiting. A controller that waits one clock late, or grants early, moves the holdAck rise. It measures the gap between holdAck falling and cycStart, which an extra or missing register would shift. It also checks that hold is blocked under lock, honoured in reset, and that a hold ending during backoff leaves the bus owned instead of acknowledged.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  typedef enum logic [1:0] {
    OWN_BUS    = 2'd0,
    HELD_BUS   = 2'd1,
    BACKED_OFF = 2'd2
  } ownState_t;

  // strobes from ownership control to the cycle slot
  typedef struct packed {
    logic issue;     // launch the waiting cycle
    logic abort;     // drop the running cycle, keep it waiting
    logic complete;  // running cycle ended by ready
  } slotCtl_t;
endpackage

// File: rtl/bhc_slot_path.sv
module bhc_slot_path
  import bhc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycReq,
  input  logic [ADDR_W-1:0] cycAddr,
  input  slotCtl_t          ctl,
  output logic              slotValid,
  output logic              slotIssued,
  output logic              cycStart,
  output logic [ADDR_W-1:0] cycAddrOut,
  output logic              coreReady
);
  logic [ADDR_W-1:0] slotAddr;

  assign coreReady = !slotValid && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotValid  <= 1'b0;
      slotIssued <= 1'b0;
      slotAddr   <= '0;
      cycStart   <= 1'b0;
      cycAddrOut <= '0;
    end else begin
      cycStart <= ctl.issue;
      if (ctl.issue) cycAddrOut <= slotAddr;
      if (ctl.abort) begin
        slotIssued <= 1'b0;
      end else if (ctl.complete) begin
        slotValid  <= 1'b0;
        slotIssued <= 1'b0;
      end else if (ctl.issue) begin
        slotIssued <= 1'b1;
      end
      if (cycReq && coreReady) begin
        slotValid <= 1'b1;
        slotAddr  <= cycAddr;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    cycStart |=> !cycStart); // R2
  AST_ABORT_KEEPS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (ctl.abort && slotValid) |=> (slotValid && !slotIssued)); // R8
  AST_ISSUE_NEEDS_SLOT: assert property (@(posedge clk) disable iff (rst)
    ctl.issue |-> (slotValid && !slotIssued)); // R9
endmodule

// File: rtl/bhc_own_ctl.sv
module bhc_own_ctl
  import bhc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     addrHoldReq,
  input  logic     backoffReq,
  input  logic     holdReq,
  input  logic     lockActive,
  input  logic     cycReady,
  input  logic     slotValid,
  input  logic     slotIssued,
  output slotCtl_t ctl,
  output logic     holdAck,
  output logic     addrOe,
  output logic     busOe
);
  ownState_t st, stNext;
  logic aholdQ;
  logic holdWanted;

  assign holdWanted = holdReq && !lockActive;

  always_comb begin
    stNext       = st;
    ctl          = '0;
    ctl.abort    = backoffReq && slotIssued;
    ctl.complete = slotIssued && cycReady && !backoffReq;
    case (st)
      OWN_BUS: begin
        if (backoffReq) stNext = BACKED_OFF;
        else if (holdWanted && (!slotIssued || cycReady)) stNext = HELD_BUS;
        else ctl.issue = slotValid && !slotIssued && !aholdQ &&
                         !addrHoldReq && !holdWanted;
      end
      HELD_BUS: begin
        if (backoffReq) stNext = BACKED_OFF;
        else if (!holdReq) stNext = OWN_BUS;
      end
      BACKED_OFF: begin
        if (!backoffReq) stNext = holdWanted ? HELD_BUS : OWN_BUS;
      end
      default: stNext = OWN_BUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= holdReq ? HELD_BUS : OWN_BUS;
      aholdQ <= 1'b0;
    end else begin
      st     <= stNext;
      aholdQ <= addrHoldReq;
    end
  end

  assign busOe   = (st == OWN_BUS);
  assign holdAck = (st == HELD_BUS);
  assign addrOe  = busOe && !aholdQ;

  AST_AHOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    addrHoldReq |=> !addrOe); // R3
  AST_ACK_FLOATS: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> (!busOe && !addrOe)); // R4
  AST_ACK_NO_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> !slotIssued); // R4
  AST_LOCK_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (lockActive && !holdAck) |=> !holdAck); // R5
  AST_NO_ISSUE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ctl.issue |-> (busOe && !holdAck)); // R7
  AST_BOFF_FLOAT: assert property (@(posedge clk) disable iff (rst)
    backoffReq |=> (!busOe && !addrOe && !holdAck)); // R8
  AST_BOFF_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (backoffReq && holdReq) |=> !holdAck); // R11
endmodule

// File: rtl/bus_hold_ctl.sv
module bus_hold_ctl
  import bhc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrHoldReq,
  input  logic              backoffReq,
  input  logic              holdReq,
  input  logic              lockActive,
  input  logic              cycReq,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic              cycReady,
  output logic              holdAck,
  output logic              addrOe,
  output logic              busOe,
  output logic              busReq,
  output logic              cycStart,
  output logic [ADDR_W-1:0] cycAddrOut,
  output logic              coreReady
);
  slotCtl_t ctl;
  logic slotValid, slotIssued;

  bhc_own_ctl u_ctl (
    .clk(clk), .rst(rst), .addrHoldReq(addrHoldReq), .backoffReq(backoffReq),
    .holdReq(holdReq), .lockActive(lockActive), .cycReady(cycReady),
    .slotValid(slotValid), .slotIssued(slotIssued), .ctl(ctl),
    .holdAck(holdAck), .addrOe(addrOe), .busOe(busOe)
  );

  bhc_slot_path #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst(rst), .cycReq(cycReq), .cycAddr(cycAddr), .ctl(ctl),
    .slotValid(slotValid), .slotIssued(slotIssued), .cycStart(cycStart),
    .cycAddrOut(cycAddrOut), .coreReady(coreReady)
  );

  assign busReq = slotValid;

  AST_BUSREQ_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (holdAck && cycReq && coreReady) |=> busReq); // R10
endmodule

// File: tb/bus_hold_ctl_test.sv
`timescale 1ns/1ps
module bus_hold_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addrHoldReq = 0, backoffReq = 0, holdReq = 0, lockActive = 0;
  logic cycReq = 0, cycReady = 0;
  logic [31:0] cycAddr = '0;
  logic holdAck, addrOe, busOe, busReq, cycStart, coreReady;
  logic [31:0] cycAddrOut;
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bus_hold_ctl uut (
    .clk(clk), .rst(rst), .addrHoldReq(addrHoldReq), .backoffReq(backoffReq),
    .holdReq(holdReq), .lockActive(lockActive), .cycReq(cycReq),
    .cycAddr(cycAddr), .cycReady(cycReady), .holdAck(holdAck),
    .addrOe(addrOe), .busOe(busOe), .busReq(busReq), .cycStart(cycStart),
    .cycAddrOut(cycAddrOut), .coreReady(coreReady)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 5000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic startCycle(input logic [31:0] a, input string req);
    cycReq = 1; cycAddr = a;
    step();
    cycReq = 0;
    chk(req, "cycStart low before launch", cycStart, 0);
    step();
    chk(req, "cycStart pulse", cycStart, 1);
    chk(req, "launched address", cycAddrOut, a);
  endtask

  task automatic finishCycle(input string req);
    cycReady = 1;
    step();
    cycReady = 0;
    chk(req, "busReq after ready", busReq, 0);
    chk(req, "coreReady after ready", coreReady, 1);
  endtask

  task automatic testReset();
    holdReq = 1;
    step(); step();
    chk("R6", "holdAck in reset", holdAck, 1);
    chk("R6", "busOe in reset", busOe, 0);
    holdReq = 0;
    step();
    chk("R6", "holdAck drops in reset", holdAck, 0);
    rst = 0;
    step();
    chk("R1", "busOe", busOe, 1);
    chk("R1", "addrOe", addrOe, 1);
    chk("R1", "holdAck", holdAck, 0);
    chk("R1", "busReq", busReq, 0);
    chk("R1", "cycStart", cycStart, 0);
    chk("R1", "coreReady", coreReady, 1);
  endtask

  task automatic testIssue();
    cycReq = 1; cycAddr = 32'h1234_5678;
    step();
    cycReq = 0;
    chk("R2", "busReq after accept", busReq, 1);
    chk("R2", "coreReady after accept", coreReady, 0);
    chk("R2", "cycStart early", cycStart, 0);
    step();
    chk("R2", "cycStart", cycStart, 1);
    chk("R2", "cycAddrOut", cycAddrOut, 32'h1234_5678);
    step();
    chk("R2", "cycStart single pulse", cycStart, 0);
    finishCycle("R2");
  endtask

  task automatic testAddrHold();
    startCycle(32'hA0A0_0001, "R3");
    addrHoldReq = 1;
    step();
    chk("R3", "addrOe off", addrOe, 0);
    chk("R3", "busOe on", busOe, 1);
    finishCycle("R3");
    cycReq = 1; cycAddr = 32'hA0A0_0002;
    step();
    cycReq = 0;
    step(); step();
    chk("R3", "no launch under address hold", cycStart, 0);
    chk("R3", "busReq waiting", busReq, 1);
    addrHoldReq = 0;
    step();
    chk("R3", "addrOe back", addrOe, 1);
    chk("R3", "no launch same clock", cycStart, 0);
    step();
    chk("R3", "launch after hold", cycStart, 1);
    chk("R3", "launch address", cycAddrOut, 32'hA0A0_0002);
    finishCycle("R3");
  endtask

  task automatic testHold();
    startCycle(32'hB000_0010, "R4");
    holdReq = 1;
    step();
    chk("R4", "no ack while outstanding", holdAck, 0);
    chk("R4", "bus still driven", busOe, 1);
    cycReady = 1;
    step();
    cycReady = 0;
    chk("R4", "ack after completion", holdAck, 1);
    chk("R4", "busOe floated", busOe, 0);
    chk("R4", "addrOe floated", addrOe, 0);
    cycReq = 1; cycAddr = 32'hB000_0020;
    step();
    cycReq = 0;
    chk("R10", "busReq while held", busReq, 1);
    chk("R10", "no launch while held", cycStart, 0);
    step();
    chk("R10", "still held", holdAck, 1);
    holdReq = 0;
    step();
    chk("R7", "ack drops", holdAck, 0);
    chk("R7", "busOe back", busOe, 1);
    chk("R7", "no launch same clock", cycStart, 0);
    step();
    chk("R7", "launch one clock later", cycStart, 1);
    chk("R7", "launch address", cycAddrOut, 32'hB000_0020);
    finishCycle("R7");
  endtask

  task automatic testLock();
    lockActive = 1; holdReq = 1;
    step(); step(); step();
    chk("R5", "hold ignored under lock", holdAck, 0);
    chk("R5", "bus kept under lock", busOe, 1);
    lockActive = 0;
    step();
    chk("R5", "ack after unlock", holdAck, 1);
    holdReq = 0;
    step();
    chk("R5", "ack released", holdAck, 0);
  endtask

  task automatic testBackoff();
    startCycle(32'hC0DE_0042, "R8");
    backoffReq = 1; cycReady = 1;
    step();
    cycReady = 0;
    chk("R8", "busOe floated", busOe, 0);
    chk("R8", "addrOe floated", addrOe, 0);
    chk("R8", "busReq kept (aborted)", busReq, 1);
    chk("R8", "coreReady low", coreReady, 0);
    step();
    chk("R8", "still floated", busOe, 0);
    backoffReq = 0;
    step();
    chk("R9", "busOe back", busOe, 1);
    chk("R9", "no launch same clock", cycStart, 0);
    step();
    chk("R9", "reissue", cycStart, 1);
    chk("R9", "reissue address", cycAddrOut, 32'hC0DE_0042);
    finishCycle("R9");
  endtask

  task automatic testPriority();
    holdReq = 1; backoffReq = 1;
    step();
    chk("R11", "no ack during backoff", holdAck, 0);
    chk("R11", "floated", busOe, 0);
    step();
    chk("R11", "no ack during backoff 2", holdAck, 0);
    backoffReq = 0;
    step();
    chk("R11", "ack after backoff", holdAck, 1);
    holdReq = 0;
    step();
    chk("R11", "ack released", holdAck, 0);
    holdReq = 1; backoffReq = 1;
    step();
    holdReq = 0;
    step();
    backoffReq = 0;
    step();
    chk("R11", "no ack when hold gone", holdAck, 0);
    chk("R11", "bus owned", busOe, 1);
  endtask

  initial begin
    step();
    testReset();
    testIssue();
    testAddrHold();
    testHold();
    testLock();
    testBackoff();
    testPriority();
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule